// File: doc/BRIEF.md
# Trace capture circular buffer

This block is the storage end of an on-chip trace path. Trace words arrive on a valid/ready stream and are written into a circular RAM at a word-granular write pointer that wraps at the RAM depth. When the pointer wraps during capture, a sticky full flag is raised. From then on, the location under the write pointer holds the oldest surviving word, which tells software where the history begins.

Software controls the block over a simple register bus with select, write, address and write-data signals and combinational read data. Through it, software enables capture and programs a post-trigger word count. It sets the stop conditions and can start a manual flush that clears itself. It can also read and write the RAM through two auto-incrementing data windows that each have their own pointer. A trigger pulse, armed by the stop-on-trigger bit, lets a programmed number of further words in and then closes the stream. A completed flush can also close the stream when stop-on-flush is set. A formatter-idle status bit reports when capture is off or stopped and no flush is pending.

Top module: `trace_ring_sink`

## Requirements
- R1: After reset both pointers are 0, the full flag is 0, capture is disabled, `tr_ready` is 0, the formatter control register (0x304) reads 0 and the formatter status register (0x300) reads 0x2.
- R2: A trace word is accepted (`tr_ready`=1) only while control bit 0 at 0x020 is 1, capture is not stopped, and the bus is not writing 0x024 or 0x018 in that cycle. Each accepted word is stored at the write pointer (0x018), and the pointer then advances, wrapping from DEPTH-1 to 0.
- R3: Status bit 0 at 0x00C sets when a captured word is stored at location DEPTH-1. It stays set until the write pointer register 0x018 is written, which clears it. Writes through the data window never set it.
- R4: While the full flag is set, the word at the write pointer is the oldest word still stored.
- R5: A write to 0x024 stores the bus word at the write pointer and advances that pointer. A read of 0x010 returns the word at the read pointer (0x014) and advances that pointer. Both pointers wrap at DEPTH and can be read and loaded directly.
- R6: With formatter control bit 13 set, a `trig_in` pulse during capture loads the count held at 0x01C. Exactly that many further words are then accepted, after which `tr_ready` drops and capture stops. A count of 0 stops capture at once.
- R7: With formatter control bit 13 clear, `trig_in` has no effect on acceptance.
- R8: Writing 0x304 with bit 6 set starts a flush. Bit 6 reads 1 for FLUSH_LAT cycles and then returns to 0 by itself. Bits 0, 12 and 13 read back as written.
- R9: If formatter control bit 12 is set when a flush completes, capture stops. If it is clear, capture continues.
- R10: Formatter status bit 1 at 0x300 reads 1 when capture is disabled or stopped and no flush is in progress, and reads 0 otherwise.
- R11: Writing control bit 0 from 0 to 1 clears the stopped state and any armed trigger.
- R12: The depth register at 0x004 reads DEPTH, and its bit 31 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| tr_valid | input | 1 | Trace word offered |
| tr_ready | output | 1 | Trace word can be taken |
| tr_data | input | 32 | Trace word |
| trig_in | input | 1 | Trigger event pulse |

## Verification
The main capture path is driven from a vector table. Each vector varies the words stored before the trigger, the post-trigger count and the number of words offered afterwards. This separates four cases: a run cut short by the count, a run that ends before the count expires, a zero count, and runs that wrap the RAM exactly at the boundary or past it. In each case the bench checks the write pointer, the full flag, the stopped status, the newest word and, once the RAM has wrapped, the oldest word at the write pointer. Directed cases then separate the ways the stream can be closed: capture disabled, a bus write that collides with a trace beat, a trigger with its stop bit clear, and a flush with and without stop-on-flush.

// File: rtl/trs_pkg.sv
package trs_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 12;

  // register offsets (byte addresses)
  localparam logic [ADDR_W-1:0] A_FMT_CTRL  = 12'h304;
  localparam logic [ADDR_W-1:0] A_FMT_STAT  = 12'h300;
  localparam logic [ADDR_W-1:0] A_RUN       = 12'h020;
  localparam logic [ADDR_W-1:0] A_POSTTRIG  = 12'h01C;
  localparam logic [ADDR_W-1:0] A_WR_IDX    = 12'h018;
  localparam logic [ADDR_W-1:0] A_RD_IDX    = 12'h014;
  localparam logic [ADDR_W-1:0] A_WR_WIN    = 12'h024;
  localparam logic [ADDR_W-1:0] A_RD_WIN    = 12'h010;
  localparam logic [ADDR_W-1:0] A_FLAGS     = 12'h00C;
  localparam logic [ADDR_W-1:0] A_CAPACITY  = 12'h004;

  // bit positions
  localparam int B_RUN        = 0;
  localparam int B_FULL       = 0;
  localparam int B_FMT_EN     = 0;
  localparam int B_FLUSH      = 6;
  localparam int B_STOP_FLUSH = 12;
  localparam int B_STOP_TRIG  = 13;
  localparam int B_FMT_IDLE   = 1;

  // next position on a ring of the given size
  function automatic int unsigned ring_next(input int unsigned p, input int unsigned size);
    return (p + 1 >= size) ? 0 : p + 1;
  endfunction

  // fold a software-supplied index onto the ring
  function automatic int unsigned ring_load(input int unsigned v, input int unsigned size);
    return v % size;
  endfunction
endpackage

// File: rtl/trs_ring_ram.sv
module trs_ring_ram #(
  parameter int DEPTH = 32,
  parameter int W     = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [PW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/trs_regfile.sv
module trs_regfile
  import trs_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CNT_W = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  // decoded strobes
  output logic              wr_data_stb,
  output logic              rd_data_stb,
  output logic              wr_wptr_stb,
  output logic              wr_rptr_stb,
  output logic              flush_req,
  output logic              cap_rise,
  // configuration
  output logic              cap_en,
  output logic [CNT_W-1:0]  trig_count,
  output logic              stop_on_flush,
  output logic              stop_on_trig,
  // readback sources
  input  logic [BUS_W-1:0]  ram_q,
  input  logic [PW-1:0]     rd_ptr,
  input  logic [PW-1:0]     wr_ptr,
  input  logic              full,
  input  logic              flush_busy,
  input  logic              fmt_idle
);
  logic wr_acc, rd_acc;
  logic fmt_en;
  logic unused_wdata;

  assign wr_acc = bus_sel &  bus_wr;
  assign rd_acc = bus_sel & ~bus_wr;
  assign unused_wdata = ^bus_wdata;

  assign wr_data_stb = wr_acc && (bus_addr == A_WR_WIN);
  assign wr_wptr_stb = wr_acc && (bus_addr == A_WR_IDX);
  assign wr_rptr_stb = wr_acc && (bus_addr == A_RD_IDX);
  assign rd_data_stb = rd_acc && (bus_addr == A_RD_WIN);
  assign flush_req   = wr_acc && (bus_addr == A_FMT_CTRL) && bus_wdata[B_FLUSH];
  assign cap_rise    = wr_acc && (bus_addr == A_RUN) && bus_wdata[B_RUN] && !cap_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_en        <= 1'b0;
      trig_count    <= '0;
      fmt_en        <= 1'b0;
      stop_on_flush <= 1'b0;
      stop_on_trig  <= 1'b0;
    end else if (wr_acc) begin
      unique case (bus_addr)
        A_RUN:      cap_en     <= bus_wdata[B_RUN];
        A_POSTTRIG: trig_count <= bus_wdata[CNT_W-1:0];
        A_FMT_CTRL: begin
          fmt_en        <= bus_wdata[B_FMT_EN];
          stop_on_flush <= bus_wdata[B_STOP_FLUSH];
          stop_on_trig  <= bus_wdata[B_STOP_TRIG];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_acc) begin
      unique case (bus_addr)
        A_CAPACITY: bus_rdata = BUS_W'(DEPTH) & 32'h7FFF_FFFF;
        A_FLAGS:    bus_rdata[B_FULL] = full;
        A_RD_WIN:   bus_rdata = ram_q;
        A_RD_IDX:   bus_rdata[PW-1:0] = rd_ptr;
        A_WR_IDX:   bus_rdata[PW-1:0] = wr_ptr;
        A_POSTTRIG: bus_rdata[CNT_W-1:0] = trig_count;
        A_RUN:      bus_rdata[B_RUN] = cap_en;
        A_FMT_STAT: bus_rdata[B_FMT_IDLE] = fmt_idle;
        A_FMT_CTRL: begin
          bus_rdata[B_FMT_EN]     = fmt_en;
          bus_rdata[B_FLUSH]      = flush_busy;
          bus_rdata[B_STOP_FLUSH] = stop_on_flush;
          bus_rdata[B_STOP_TRIG]  = stop_on_trig;
        end
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/trs_capture_ctl.sv
module trs_capture_ctl #(
  parameter int CNT_W     = 16,
  parameter int FLUSH_LAT = 4,
  localparam int FW       = (FLUSH_LAT > 1) ? $clog2(FLUSH_LAT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic             cap_rise,
  input  logic             stop_on_trig,
  input  logic             stop_on_flush,
  input  logic [CNT_W-1:0] trig_count,
  input  logic             trig_in,
  input  logic             beat,
  input  logic             flush_req,
  output logic             accept_ok,
  output logic             stopped,
  output logic             armed,
  output logic [CNT_W-1:0] words_left,
  output logic             flush_busy,
  output logic             flush_done
);
  logic [FW-1:0] flush_cnt;
  logic          count_spent;
  logic          trig_hit;

  assign count_spent = armed && (words_left == '0);
  assign accept_ok   = cap_en && !stopped && !count_spent;
  assign trig_hit    = trig_in && cap_en && !stopped && stop_on_trig && !armed;
  assign flush_done  = flush_busy && (flush_cnt == '0);

  // flush handshake: busy for FLUSH_LAT cycles, then self-clears
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_busy <= 1'b0;
      flush_cnt  <= '0;
    end else if (flush_busy) begin
      if (flush_done) flush_busy <= 1'b0;
      else            flush_cnt  <= flush_cnt - 1'b1;
    end else if (flush_req) begin
      flush_busy <= 1'b1;
      flush_cnt  <= FW'(FLUSH_LAT - 1);
    end
  end

  // trigger arming and post-trigger countdown
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      words_left <= '0;
    end else if (cap_rise) begin
      armed      <= 1'b0;
      words_left <= '0;
    end else if (trig_hit) begin
      armed      <= 1'b1;
      words_left <= trig_count;
    end else if (armed && beat && (words_left != '0)) begin
      words_left <= words_left - 1'b1;
    end
  end

  // stop state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           stopped <= 1'b0;
    else if (cap_rise)                    stopped <= 1'b0;
    else if (flush_done && stop_on_flush) stopped <= 1'b1;
    else if (count_spent && cap_en)       stopped <= 1'b1;
  end
endmodule

// File: rtl/trace_ring_sink.sv
module trace_ring_sink
  import trs_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int CNT_W     = 16,
  parameter int FLUSH_LAT = 4,
  localparam int PW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              tr_valid,
  output logic              tr_ready,
  input  logic [BUS_W-1:0]  tr_data,
  input  logic              trig_in
);
  logic             wr_data_stb, rd_data_stb, wr_wptr_stb, wr_rptr_stb;
  logic             flush_req, cap_rise, cap_en;
  logic [CNT_W-1:0] trig_count, words_left;
  logic             stop_on_flush, stop_on_trig;
  logic             accept_ok, stopped, armed, flush_busy, flush_done;
  logic             fmt_idle, beat, ram_we, wrap_hit;
  logic [PW-1:0]    wr_ptr, rd_ptr, wr_ptr_nx, rd_ptr_nx, idx_load;
  logic [BUS_W-1:0] ram_d, ram_q;
  logic             full;

  trs_regfile #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_regs (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .wr_data_stb, .rd_data_stb, .wr_wptr_stb, .wr_rptr_stb,
    .flush_req, .cap_rise, .cap_en, .trig_count, .stop_on_flush, .stop_on_trig,
    .ram_q, .rd_ptr, .wr_ptr, .full, .flush_busy, .fmt_idle
  );

  trs_capture_ctl #(.CNT_W(CNT_W), .FLUSH_LAT(FLUSH_LAT)) u_ctl (
    .clk, .rst_n, .cap_en, .cap_rise, .stop_on_trig, .stop_on_flush,
    .trig_count, .trig_in, .beat, .flush_req,
    .accept_ok, .stopped, .armed, .words_left, .flush_busy, .flush_done
  );

  trs_ring_ram #(.DEPTH(DEPTH), .W(BUS_W)) u_ram (
    .clk, .we(ram_we), .waddr(wr_ptr), .wdata(ram_d), .raddr(rd_ptr), .rdata(ram_q)
  );

  // stream side: bus writes that move the write pointer take the cycle
  assign tr_ready  = accept_ok && !wr_data_stb && !wr_wptr_stb;
  assign beat      = tr_valid && tr_ready;
  assign ram_we    = beat || wr_data_stb;
  assign ram_d     = wr_data_stb ? bus_wdata : tr_data;
  assign wrap_hit  = beat && (int'(wr_ptr) == DEPTH - 1);
  assign fmt_idle  = (!cap_en || stopped) && !flush_busy;

  assign wr_ptr_nx = PW'(ring_next(int'(wr_ptr), DEPTH));
  assign rd_ptr_nx = PW'(ring_next(int'(rd_ptr), DEPTH));
  assign idx_load  = PW'(ring_load(bus_wdata, DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      full   <= 1'b0;
    end else if (wr_wptr_stb) begin
      wr_ptr <= idx_load;
      full   <= 1'b0;
    end else begin
      if (ram_we)   wr_ptr <= wr_ptr_nx;
      if (wrap_hit) full   <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rd_ptr <= '0;
    else if (wr_rptr_stb) rd_ptr <= idx_load;
    else if (rd_data_stb) rd_ptr <= rd_ptr_nx;
  end
endmodule

// File: rtl/trs_checker.sv
module trs_checker
  import trs_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CNT_W = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tr_ready,
  input logic             cap_en,
  input logic             beat,
  input logic [PW-1:0]    wr_ptr,
  input logic [PW-1:0]    rd_ptr,
  input logic             full,
  input logic             wr_wptr_stb,
  input logic             wr_rptr_stb,
  input logic             rd_data_stb,
  input logic             armed,
  input logic [CNT_W-1:0] words_left,
  input logic             flush_done,
  input logic             stop_on_flush,
  input logic             flush_busy,
  input logic             fmt_idle,
  input logic             cap_rise,
  input logic             stopped
);
  AST_READY_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    tr_ready |-> cap_en); // R2
  AST_WRAP_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && int'(wr_ptr) == DEPTH - 1) |=> (full && wr_ptr == '0)); // R3
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !wr_wptr_stb) |=> full); // R3
  AST_PTR_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_wptr_stb |=> !full); // R3
  AST_RD_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_stb && !wr_rptr_stb) |=> (int'(rd_ptr) == int'(ring_next(int'($past(rd_ptr)), DEPTH)))); // R5
  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(wr_ptr) < DEPTH) && (int'(rd_ptr) < DEPTH)); // R5
  AST_COUNT_SPENT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && words_left == '0) |-> !tr_ready); // R6
  AST_FLUSH_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_done && stop_on_flush && !cap_rise) |=> !tr_ready); // R9
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !flush_busy) |-> fmt_idle); // R10
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cap_rise |=> (!stopped && !armed)); // R11
endmodule

bind trace_ring_sink trs_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tr_ready(tr_ready), .cap_en(cap_en), .beat(beat),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .full(full), .wr_wptr_stb(wr_wptr_stb),
  .wr_rptr_stb(wr_rptr_stb), .rd_data_stb(rd_data_stb), .armed(armed),
  .words_left(words_left), .flush_done(flush_done), .stop_on_flush(stop_on_flush),
  .flush_busy(flush_busy), .fmt_idle(fmt_idle), .cap_rise(cap_rise), .stopped(stopped)
);

// File: tb/sim_trace_ring_sink.sv
module sim_trace_ring_sink;
  import trs_pkg::*;
  localparam int DEPTH = 32;
  localparam int CNT_W = 16;
  localparam int FLUSH_LAT = 4;
  localparam int NV = 5;
  // pre-trigger words, post-trigger count, words offered after trigger
  localparam int VEC [NV][3] = '{'{4, 3, 6}, '{0, 0, 2}, '{10, 8, 5}, '{28, 8, 10}, '{31, 1, 1}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [BUS_W-1:0]  bus_wdata = '0, tr_data = '0;
  logic [BUS_W-1:0]  bus_rdata;
  logic tr_valid = 1'b0, trig_in = 1'b0, tr_ready;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  trace_ring_sink #(.DEPTH(DEPTH), .CNT_W(CNT_W), .FLUSH_LAT(FLUSH_LAT)) u0 (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .tr_valid, .tr_ready, .tr_data, .trig_in
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic push(input logic [31:0] d, output logic acc);
    @(negedge clk);
    tr_valid = 1'b1; tr_data = d;
    #2 acc = tr_ready;
    @(posedge clk); #1;
    tr_valid = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_in = 1'b1;
    @(posedge clk); #1 trig_in = 1'b0;
  endtask

  task automatic ready_now(output logic r);
    @(negedge clk); #2 r = tr_ready;
  endtask

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic acc, r;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // ---- table-driven capture runs (R2 R3 R4 R6 R10 R11)
    for (int e = 0; e < NV; e++) begin
      int pre, trg, att, k, expacc, total, wp;
      logic [31:0] base;
      pre = VEC[e][0]; trg = VEC[e][1]; att = VEC[e][2];
      base = 32'((e + 1) << 8);
      bus_write(A_RUN, 0);
      bus_write(A_WR_IDX, 0);
      bus_write(A_FMT_CTRL, 32'h2001);
      bus_write(A_POSTTRIG, 32'(trg));
      bus_write(A_RUN, 1);
      k = 0;
      for (int i = 0; i < pre; i++) begin
        push(base + 32'(k), acc);
        if (acc) k++;
      end
      check("R2 pre-trigger words accepted", 32'(k), 32'(pre));
      pulse_trig();
      for (int i = 0; i < att; i++) begin
        push(base + 32'(k), acc);
        if (acc) k++;
      end
      expacc = (att < trg) ? att : trg;
      total = pre + expacc;
      wp = total % DEPTH;
      check("R6 post-trigger words accepted", 32'(k - pre), 32'(expacc));
      bus_read(A_WR_IDX, rd);
      check("R2 write pointer after capture", rd, 32'(wp));
      bus_read(A_FLAGS, rd);
      check("R3 full flag", rd, 32'(total >= DEPTH));
      bus_read(A_FMT_STAT, rd);
      check("R10 formatter idle reflects stop", rd, (att >= trg) ? 32'h2 : 32'h0);
      if (total > 0) begin
        bus_write(A_RD_IDX, 32'((wp + DEPTH - 1) % DEPTH));
        bus_read(A_RD_WIN, rd);
        check("R2 newest word stored", rd, base + 32'(total - 1));
      end
      if (total >= DEPTH) begin
        bus_write(A_RD_IDX, 32'(wp));
        bus_read(A_RD_WIN, rd);
        check("R4 oldest word at write pointer", rd, base + 32'(total - DEPTH));
      end
    end

    // ---- directed: reset state (R1 R12)
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    ready_now(r);
    check("R1 ready low after reset", 32'(r), 0);
    bus_read(A_CAPACITY, rd);
    check("R12 depth register", rd, 32'(DEPTH));
    bus_read(A_FLAGS, rd);   check("R1 status after reset", rd, 0);
    bus_read(A_RUN, rd);     check("R1 control after reset", rd, 0);
    bus_read(A_WR_IDX, rd);  check("R1 write pointer after reset", rd, 0);
    bus_read(A_RD_IDX, rd);  check("R1 read pointer after reset", rd, 0);
    bus_read(A_FMT_CTRL, rd); check("R1 formatter control after reset", rd, 0);
    bus_read(A_FMT_STAT, rd); check("R1 formatter status after reset", rd, 32'h2);

    // ---- capture disabled: word refused (R2)
    push(32'hDEAD_0001, acc);
    check("R2 no accept while disabled", 32'(acc), 0);
    bus_read(A_WR_IDX, rd); check("R2 pointer unchanged while disabled", rd, 0);

    // ---- data windows with wrap; software wrap leaves full clear (R5 R3)
    bus_write(A_WR_IDX, 30);
    bus_write(A_WR_WIN, 32'hA0A0_0001);
    bus_write(A_WR_WIN, 32'hA0A0_0002);
    bus_write(A_WR_WIN, 32'hA0A0_0003);
    bus_read(A_WR_IDX, rd); check("R5 write pointer wraps", rd, 1);
    bus_read(A_FLAGS, rd);  check("R3 data window wrap does not set full", rd, 0);
    bus_write(A_RD_IDX, 30);
    bus_read(A_RD_WIN, rd); check("R5 read word 30", rd, 32'hA0A0_0001);
    bus_read(A_RD_WIN, rd); check("R5 read word 31", rd, 32'hA0A0_0002);
    bus_read(A_RD_WIN, rd); check("R5 read word 0", rd, 32'hA0A0_0003);
    bus_read(A_RD_IDX, rd); check("R5 read pointer wraps", rd, 1);

    // ---- trigger with stop bit clear is ignored (R7)
    bus_write(A_FMT_CTRL, 32'h0001);
    bus_write(A_POSTTRIG, 0);
    bus_write(A_RUN, 1);
    pulse_trig();
    begin
      int n;
      n = 0;
      for (int i = 0; i < 3; i++) begin
        push(32'hB0B0_0000 + 32'(i), acc);
        if (acc) n++;
      end
      check("R7 trigger ignored without stop bit", 32'(n), 3);
    end

    // ---- bus write to data window blocks the stream that cycle (R2)
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_WR_WIN; bus_wdata = 32'hC0C0_0001;
    tr_valid = 1'b1; tr_data = 32'hC0C0_0002;
    #2 r = tr_ready;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0; tr_valid = 1'b0;
    check("R2 ready low during window write", 32'(r), 0);

    // ---- flush with stop-on-flush (R8 R9 R10)
    bus_write(A_FMT_CTRL, 32'h1041);
    bus_read(A_FMT_CTRL, rd); check("R8 flush bit reads busy", rd, 32'h1041);
    bus_read(A_FMT_STAT, rd); check("R10 not idle during flush", rd, 0);
    repeat (FLUSH_LAT) @(posedge clk);
    bus_read(A_FMT_CTRL, rd); check("R8 flush bit self-clears", rd, 32'h1001);
    ready_now(r);
    check("R9 stop after flush", 32'(r), 0);
    bus_read(A_FMT_STAT, rd); check("R10 idle once stopped", rd, 32'h2);

    // ---- restart clears stop (R11)
    bus_write(A_RUN, 0);
    bus_write(A_RUN, 1);
    ready_now(r);
    check("R11 restart reopens stream", 32'(r), 1);

    // ---- flush without stop-on-flush keeps capturing (R9)
    bus_write(A_FMT_CTRL, 32'h0041);
    repeat (FLUSH_LAT + 2) @(posedge clk);
    ready_now(r);
    check("R9 capture continues after plain flush", 32'(r), 1);

    // ---- capture wrap sets full, pointer load clears it (R3)
    bus_write(A_WR_IDX, 31);
    push(32'hD0D0_0001, acc);
    bus_read(A_FLAGS, rd); check("R3 capture wrap sets full", rd, 1);
    bus_read(A_WR_IDX, rd); check("R2 pointer wrapped to 0", rd, 0);
    bus_write(A_WR_IDX, 5);
    bus_read(A_FLAGS, rd); check("R3 pointer load clears full", rd, 0);

    // ---- disable capture (R10 R2)
    bus_write(A_RUN, 0);
    ready_now(r);
    check("R2 ready low after disable", 32'(r), 0);
    bus_read(A_FMT_STAT, rd); check("R10 idle when disabled", rd, 32'h2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule